// File: doc/BRIEF.md
# VME Bus Interrupter with Re-raise Timer

This block sits between a local bus slave and the VME backplane. A level-sensitive interrupt request from the local side is raised on one of the seven active-low bus interrupt lines, chosen by a three-bit priority input. When the bus interrupt handler runs an acknowledge cycle for that priority, the block answers with an 8-bit status/ID vector and DTACK. It also gives the local interrupt controller a single-cycle acknowledge strobe. Acknowledge cycles that are not meant for this block are passed down the daisy chain on IACKOUT.

A handler may acknowledge the interrupt without silencing the local source. In that case the block keeps the line quiet for a fixed hold-off, 1 ms by default, and then raises it again. The hold-off is counted in clock cycles derived from the clock-period parameter. A priority of zero disables the interrupter. The bus strobes and the acknowledged level are asynchronous to the local clock and pass through a synchronizer before they are used.

Top module: `vme_irq_relay`

## Requirements
- R1: While reset is held and directly after it, all seven IRQ lines are high, DTACK and IACKOUT are high (inactive), data-enable is low and the acknowledge strobe is low.
- R2: With the request high and a priority p in 1..7, the block drives irq_n_o[p] low within three clocks. At most one IRQ line is low at any time.
- R3: With priority 0, a request drives no IRQ line.
- R4: The priority is captured when the interrupt becomes pending. A later change of the priority input does not move the asserted line before the acknowledge.
- R5: An acknowledge cycle has iack_n_i, iackin_n_i and ds_n_i all low. If it arrives while pending and ack_level_i equals the captured priority, the block drives data_o equal to vector_i with data_oe_o high and dtack_n_o low. DTACK is never low without data-enable.
- R6: Each acknowledge that the block answers makes ack_pulse_o high for exactly one clock.
- R7: The clock after the acknowledge strobe, all IRQ lines are high and the pending state is cleared.
- R8: An acknowledge cycle for another level, or one that arrives while nothing is pending, pulls iackout_n_o low. In that case the block drives neither data nor DTACK and gives no acknowledge strobe.
- R9: Once ds_n_i returns high, DTACK, data-enable and IACKOUT are all released within six clocks.
- R10: If the request is still high after an acknowledge, the block raises the line again with the priority input of that moment. The delay from the acknowledge strobe is no less than RETRY_CYCLES = ceil(RETRY_NS / CLK_PERIOD_NS) clocks and no more than two clocks beyond that.
- R11: If the request drops during the hold-off, no line is raised when the hold-off ends. A new request after that is raised within three clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Level interrupt request from the local slave |
| level_i | input | 3 | Interrupt priority, 0 disables |
| vector_i | input | 8 | Status/ID returned in the acknowledge cycle |
| iack_n_i | input | 1 | Bus acknowledge-cycle indicator, active low |
| iackin_n_i | input | 1 | Daisy-chain acknowledge input, active low |
| ds_n_i | input | 1 | Bus data strobe, active low |
| ack_level_i | input | 3 | Priority being acknowledged on the bus |
| irq_n_o | output | 7 | Bus interrupt lines 7..1, active low |
| data_o | output | 8 | Vector data toward the bus |
| data_oe_o | output | 1 | Data output enable |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| iackout_n_o | output | 1 | Daisy-chain acknowledge output, active low |
| ack_pulse_o | output | 1 | One-clock strobe when the bus acknowledges |

## Verification
The bench attacks the captured priority. A design that followed the live level input would move the asserted line, or would answer an acknowledge cycle for a level that is not pending. It also sends mismatched-level cycles and cycles with nothing pending. A responder that wrongly answered these would drive DTACK on a cycle owned by another board further down the chain. The re-raise delay is measured in clocks from the acknowledge strobe. A timer off by a few cycles, or a design that never re-raised, would fail that window. A request dropped during the hold-off must stay silent, or a handled source would be raised again. Randomized levels, vectors and match/mismatch choices from a fixed seed cover the ordinary cases between these directed ones.

// File: rtl/vme_irq_pkg.sv
package vme_irq_pkg;

    typedef enum logic [1:0] {
        IRQ_IDLE    = 2'd0,
        IRQ_PENDING = 2'd1,
        IRQ_HOLDOFF = 2'd2
    } irq_state_e;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_ANSWER = 2'd1,
        RSP_PASS   = 2'd2
    } rsp_state_e;

    // Synchronized view of the bus acknowledge-cycle inputs (raw polarity)
    typedef struct packed {
        logic       iack_n;
        logic       iackin_n;
        logic       ds_n;
        logic [2:0] level;
    } bus_view_t;

    localparam int BUS_VIEW_W = $bits(bus_view_t);

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic logic [7:1] lines_for_level(input logic [2:0] lvl);
        logic [7:1] lines;
        lines = '1;
        for (int i = 1; i <= 7; i++) begin
            if (lvl == i[2:0]) lines[i] = 1'b0;
        end
        return lines;
    endfunction

endpackage

// File: rtl/vme_irq_sync.sv
module vme_irq_sync #(
    parameter int              WIDTH     = 6,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] q_r;
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q_r <= RESET_VAL;
                    else     q_r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q_r <= RESET_VAL;
                    else     q_r <= g_stage[g-1].q_r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/vme_irq_ctrl.sv
module vme_irq_ctrl
    import vme_irq_pkg::*;
#(
    parameter int RETRY_CYCLES = 100000,
    localparam int CNT_W = $clog2(RETRY_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic [2:0] level,
    input  logic       ack_strobe,
    output logic       pending,
    output logic [2:0] level_q,
    output logic [7:1] irq_n
);

    irq_state_e       state_q;
    logic [CNT_W-1:0] wait_q;
    logic             raise_ok;

    assign raise_ok = req && (level != 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IRQ_IDLE;
            level_q <= 3'd0;
            wait_q  <= '0;
        end else begin
            case (state_q)
                IRQ_IDLE: begin
                    if (raise_ok) begin
                        state_q <= IRQ_PENDING;
                        level_q <= level;
                    end
                end
                IRQ_PENDING: begin
                    if (ack_strobe) begin
                        state_q <= IRQ_HOLDOFF;
                        wait_q  <= CNT_W'(RETRY_CYCLES - 1);
                    end
                end
                IRQ_HOLDOFF: begin
                    if (!req) begin
                        state_q <= IRQ_IDLE;
                    end else if (wait_q == '0) begin
                        if (raise_ok) begin
                            state_q <= IRQ_PENDING;
                            level_q <= level;
                        end else begin
                            state_q <= IRQ_IDLE;
                        end
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                default: state_q <= IRQ_IDLE;
            endcase
        end
    end

    assign pending = (state_q == IRQ_PENDING);
    assign irq_n   = pending ? lines_for_level(level_q) : '1;

endmodule

// File: rtl/vme_irq_iack.sv
module vme_irq_iack
    import vme_irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_view_t        bus,
    input  logic             pending,
    input  logic [2:0]       level_q,
    input  logic [VEC_W-1:0] vector,
    output logic [VEC_W-1:0] data,
    output logic             data_oe,
    output logic             dtack_n,
    output logic             iackout_n,
    output logic             ack_strobe
);

    rsp_state_e       state_q;
    logic [VEC_W-1:0] data_q;
    logic             cycle_on;
    logic             ours;

    assign cycle_on = !bus.iack_n && !bus.iackin_n && !bus.ds_n;
    assign ours     = pending && (bus.level == level_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RSP_IDLE;
            data_q     <= '0;
            ack_strobe <= 1'b0;
        end else begin
            ack_strobe <= 1'b0;
            case (state_q)
                RSP_IDLE: begin
                    if (cycle_on) begin
                        if (ours) begin
                            state_q    <= RSP_ANSWER;
                            data_q     <= vector;
                            ack_strobe <= 1'b1;
                        end else begin
                            state_q <= RSP_PASS;
                        end
                    end
                end
                RSP_ANSWER: begin
                    if (bus.ds_n) begin
                        state_q <= RSP_IDLE;
                        data_q  <= '0;
                    end
                end
                RSP_PASS: begin
                    if (bus.ds_n || bus.iackin_n) state_q <= RSP_IDLE;
                end
                default: state_q <= RSP_IDLE;
            endcase
        end
    end

    assign data      = data_q;
    assign data_oe   = (state_q == RSP_ANSWER);
    assign dtack_n   = (state_q != RSP_ANSWER);
    assign iackout_n = (state_q != RSP_PASS);

endmodule

// File: rtl/vme_irq_relay.sv
module vme_irq_relay
    import vme_irq_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int RETRY_NS      = 1000000,
    parameter int SYNC_STAGES   = 2,
    parameter int VEC_W         = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [2:0]       level_i,
    input  logic [VEC_W-1:0] vector_i,
    input  logic             iack_n_i,
    input  logic             iackin_n_i,
    input  logic             ds_n_i,
    input  logic [2:0]       ack_level_i,
    output logic [7:1]       irq_n_o,
    output logic [VEC_W-1:0] data_o,
    output logic             data_oe_o,
    output logic             dtack_n_o,
    output logic             iackout_n_o,
    output logic             ack_pulse_o
);

    localparam int RETRY_CYCLES = ceil_div(RETRY_NS, CLK_PERIOD_NS) < 1 ? 1
                                : ceil_div(RETRY_NS, CLK_PERIOD_NS);

    bus_view_t  bus_raw;
    bus_view_t  bus_s;
    logic       pending;
    logic [2:0] level_q;
    logic       ack_strobe;

    assign bus_raw = '{iack_n: iack_n_i, iackin_n: iackin_n_i,
                       ds_n: ds_n_i, level: ack_level_i};

    vme_irq_sync #(
        .WIDTH     (BUS_VIEW_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({BUS_VIEW_W{1'b1}})
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_raw),
        .q   (bus_s)
    );

    vme_irq_ctrl #(
        .RETRY_CYCLES (RETRY_CYCLES)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req_i),
        .level      (level_i),
        .ack_strobe (ack_strobe),
        .pending    (pending),
        .level_q    (level_q),
        .irq_n      (irq_n_o)
    );

    vme_irq_iack #(
        .VEC_W (VEC_W)
    ) i_iack (
        .clk        (clk),
        .rst        (rst),
        .bus        (bus_s),
        .pending    (pending),
        .level_q    (level_q),
        .vector     (vector_i),
        .data       (data_o),
        .data_oe    (data_oe_o),
        .dtack_n    (dtack_n_o),
        .iackout_n  (iackout_n_o),
        .ack_strobe (ack_strobe)
    );

    assign ack_pulse_o = ack_strobe;

endmodule

// File: rtl/vme_irq_relay_chk.sv
module vme_irq_relay_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:1] irq_n_o,
    input logic       data_oe_o,
    input logic       dtack_n_o,
    input logic       iackout_n_o,
    input logic       ack_pulse_o
);

    AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (rst)
        $countones(~irq_n_o) <= 1); // R2

    AST_LINE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!(&irq_n_o) && !(&$past(irq_n_o))) |-> (irq_n_o == $past(irq_n_o))); // R4

    AST_DTACK_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        !dtack_n_o |-> data_oe_o); // R5

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_pulse_o |=> !ack_pulse_o); // R6

    AST_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        ack_pulse_o |=> (&irq_n_o)); // R7

    AST_ANSWER_OR_PASS: assert property (@(posedge clk) disable iff (rst)
        !(data_oe_o && !iackout_n_o)); // R8

endmodule

bind vme_irq_relay vme_irq_relay_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_n_o     (irq_n_o),
    .data_oe_o   (data_oe_o),
    .dtack_n_o   (dtack_n_o),
    .iackout_n_o (iackout_n_o),
    .ack_pulse_o (ack_pulse_o)
);

// File: tb/test_vme_irq_relay.sv
module test_vme_irq_relay;

    localparam int CLK_NS   = 10;
    localparam int RETRY_NS = 500;
    localparam int RC       = (RETRY_NS + CLK_NS - 1) / CLK_NS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_i = 1'b0;
    logic [2:0] level_i = 3'd0;
    logic [7:0] vector_i = 8'h00;
    logic       iack_n_i = 1'b1;
    logic       iackin_n_i = 1'b1;
    logic       ds_n_i = 1'b1;
    logic [2:0] ack_level_i = 3'd0;
    logic [7:1] irq_n_o;
    logic [7:0] data_o;
    logic       data_oe_o;
    logic       dtack_n_o;
    logic       iackout_n_o;
    logic       ack_pulse_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pulses = 0;
    int last_pulse_cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vme_irq_relay #(.CLK_PERIOD_NS(CLK_NS), .RETRY_NS(RETRY_NS)) i_vme_irq_relay (
        .clk(clk), .rst(rst), .req_i(req_i), .level_i(level_i), .vector_i(vector_i),
        .iack_n_i(iack_n_i), .iackin_n_i(iackin_n_i), .ds_n_i(ds_n_i),
        .ack_level_i(ack_level_i), .irq_n_o(irq_n_o), .data_o(data_o),
        .data_oe_o(data_oe_o), .dtack_n_o(dtack_n_o), .iackout_n_o(iackout_n_o),
        .ack_pulse_o(ack_pulse_o)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst && ack_pulse_o) begin
            pulses = pulses + 1;
            last_pulse_cyc = cyc;
        end
    end

    function automatic logic [7:1] want_lines(input logic [2:0] p);
        logic [7:1] w = 7'h7f;
        if (p != 3'd0) w[p] = 1'b0;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // kind: 0 no reaction, 1 answered, 2 passed down the chain
    task automatic run_iack(input logic [2:0] lvl, output int kind, output logic [7:0] vec);
        bit released;
        kind = 0;
        vec  = 8'h00;
        @(negedge clk);
        ack_level_i = lvl;
        iack_n_i = 1'b0; iackin_n_i = 1'b0; ds_n_i = 1'b0;
        for (int i = 0; i < 12 && kind == 0; i++) begin
            @(negedge clk);
            if (!dtack_n_o) begin
                kind = 1;
                vec  = data_o;
                check(data_oe_o == 1'b1, "R5", "data enable with dtack", data_oe_o, 1);
            end else if (!iackout_n_o) begin
                kind = 2;
                check(data_oe_o == 1'b0, "R8", "no data on pass", data_oe_o, 0);
            end
        end
        wait_cycles(2);
        ds_n_i = 1'b1; iackin_n_i = 1'b1; iack_n_i = 1'b1;
        released = 0;
        for (int i = 0; i < 6 && !released; i++) begin
            @(negedge clk);
            released = dtack_n_o && !data_oe_o && iackout_n_o;
        end
        check(released, "R9", "release after strobe", released, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails = fails + 1;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int kind;
        logic [7:0] vec;
        int p0;
        int t0;
        bit seen;
        void'($urandom(32'h5eed_0042));

        // R1: reset state
        wait_cycles(3);
        check(irq_n_o == 7'h7f, "R1", "irq in reset", irq_n_o, 7'h7f);
        check(dtack_n_o && iackout_n_o && !data_oe_o && !ack_pulse_o, "R1", "bus outputs in reset",
              {dtack_n_o, iackout_n_o, data_oe_o, ack_pulse_o}, 4'b1100);
        rst = 1'b0;
        wait_cycles(2);
        check(irq_n_o == 7'h7f, "R1", "irq after reset", irq_n_o, 7'h7f);

        // R2: raise at level 3
        vector_i = 8'hA5; level_i = 3'd3; req_i = 1'b1;
        wait_cycles(3);
        check(irq_n_o == want_lines(3'd3), "R2", "line for level 3", irq_n_o, want_lines(3'd3));

        // R4: level change while pending is ignored
        level_i = 3'd6;
        wait_cycles(3);
        check(irq_n_o == want_lines(3'd3), "R4", "line held at captured level", irq_n_o, want_lines(3'd3));

        // R8: mismatched level is passed on
        p0 = pulses;
        run_iack(3'd6, kind, vec);
        check(kind == 2, "R8", "mismatch passes", kind, 2);
        check(pulses == p0, "R8", "no strobe on pass", pulses - p0, 0);
        check(irq_n_o == want_lines(3'd3), "R8", "still pending", irq_n_o, want_lines(3'd3));

        // R5 R6 R7: matching acknowledge
        p0 = pulses;
        run_iack(3'd3, kind, vec);
        check(kind == 1, "R5", "match answered", kind, 1);
        check(vec == 8'hA5, "R5", "vector", vec, 8'hA5);
        check(pulses - p0 == 1, "R6", "one strobe cycle", pulses - p0, 1);
        check(irq_n_o == 7'h7f, "R7", "line released", irq_n_o, 7'h7f);

        // R10: request held, re-raise after hold-off at the new level 6
        seen = 0;
        for (int i = 0; i < RC + 20 && !seen; i++) begin
            @(negedge clk);
            seen = (irq_n_o != 7'h7f);
        end
        t0 = cyc - last_pulse_cyc;
        check(seen && t0 >= RC && t0 <= RC + 2, "R10", "re-raise delay", t0, RC);
        check(irq_n_o == want_lines(3'd6), "R10", "re-raise level", irq_n_o, want_lines(3'd6));

        // R11: request dropped during hold-off stays silent
        run_iack(3'd6, kind, vec);
        check(kind == 1, "R11", "ack before drop", kind, 1);
        req_i = 1'b0;
        seen = 0;
        for (int i = 0; i < RC + 10; i++) begin
            @(negedge clk);
            if (irq_n_o != 7'h7f) seen = 1;
        end
        check(!seen, "R11", "no re-raise after drop", seen, 0);
        level_i = 3'd2; req_i = 1'b1;
        wait_cycles(3);
        check(irq_n_o == want_lines(3'd2), "R11", "fresh request raised", irq_n_o, want_lines(3'd2));
        run_iack(3'd2, kind, vec);
        req_i = 1'b0;
        wait_cycles(3);

        // R3: level 0 raises nothing; R8: nothing pending passes
        level_i = 3'd0; req_i = 1'b1;
        wait_cycles(8);
        check(irq_n_o == 7'h7f, "R3", "level 0 silent", irq_n_o, 7'h7f);
        p0 = pulses;
        run_iack(3'd1, kind, vec);
        check(kind == 2 && pulses == p0, "R8", "idle passes", kind, 2);
        req_i = 1'b0;
        wait_cycles(3);

        // randomized rounds
        for (int r = 0; r < 30; r++) begin
            logic [2:0] lv;
            logic [2:0] al;
            logic [7:0] vv;
            lv = 3'($urandom_range(0, 7));
            vv = 8'($urandom);
            vector_i = vv; level_i = lv; req_i = 1'b1;
            wait_cycles(3);
            check(irq_n_o == want_lines(lv), (lv == 0) ? "R3" : "R2", "random line", irq_n_o, want_lines(lv));
            if (lv != 3'd0) begin
                al = ($urandom_range(0, 1) == 0) ? lv : 3'($urandom_range(0, 7));
                p0 = pulses;
                run_iack(al, kind, vec);
                if (al == lv) begin
                    check(kind == 1 && vec == vv, "R5", "random answer", vec, vv);
                    check(pulses - p0 == 1, "R6", "random strobe", pulses - p0, 1);
                end else begin
                    check(kind == 2 && pulses == p0, "R8", "random pass", kind, 2);
                    run_iack(lv, kind, vec);
                end
                req_i = 1'b0;
                wait_cycles(2);
                check(irq_n_o == 7'h7f, "R7", "random release", irq_n_o, 7'h7f);
            end else begin
                req_i = 1'b0;
                wait_cycles(2);
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule